// File: doc/BRIEF.md
# Boot Image Copier

After a reset, this block copies a fixed byte-wide program image from an on-chip ROM into byte-wide RAM. The processor core stays idle while the copy runs. A byte address starts at zero and advances by one on every cycle. The ROM byte at each address is written to the same address in RAM. The copied range holds the program image, which starts at address 0x0000. It also holds a preloaded input text buffer starting at 0x1000. That buffer has to come from the ROM because no receive path exists to fill it.

The ROM answers a read one cycle after the address is presented. Each RAM write therefore uses the address and the read-enable captured on the cycle before. Because of this pipeline stage, one flush cycle follows the final ROM read. On the cycle after the last RAM write, the done flag rises and stays high. The hold on the core is released at the same time.

The sequencing is a three-state machine. ST_COPY issues one ROM read per cycle. Its transition "last address read" leads to ST_FLUSH, which retires the final write. Its transition "always" then leads to ST_DONE, which holds until reset. A synchronous reset from any state returns the machine to ST_COPY at address zero.

Top module: `boot_image_copier`

## Requirements
- R1: While `rst` is high, `boot_done` is 0, `core_hold` is 1 and `ram_we` is 0.
- R2: On the first cycle after `rst` falls, `rom_rd_en` is 1 and `rom_addr` is 0.
- R3: While reads are issued, `rom_addr` rises by exactly one each cycle. It goes from 0 to IMAGE_BYTES-1 (8191 by default), exactly IMAGE_BYTES reads in all, and then `rom_rd_en` falls.
- R4: Each ROM read is followed on the next cycle by a RAM write to the same address. That write carries the byte the ROM returned, taken from `rom_data`.
- R5: A copy writes exactly IMAGE_BYTES bytes, in ascending order from 0. This covers the program image at 0x0000 and the input text buffer at 0x1000 up to the top address 0x1FFF.
- R6: `boot_done` first rises on the cycle after the last RAM write. Counting cycles from the first cycle after reset release as cycle 0, the last write is at cycle IMAGE_BYTES and `boot_done` rises at cycle IMAGE_BYTES+1. `core_hold` is 1 on every cycle that `boot_done` is 0.
- R7: Once `boot_done` is 1, it stays 1 until reset, and no further ROM reads or RAM writes occur.
- R8: A synchronous reset at any time clears `boot_done`. After release, the copy restarts from address 0 and completes in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_addr | output | ADDR_W (13) | ROM byte address |
| rom_data | input | DATA_W (8) | ROM read data, valid one cycle after the read |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W (13) | RAM byte address |
| ram_wdata | output | DATA_W (8) | RAM write data |
| core_hold | output | 1 | Holds the core in reset while high |
| boot_done | output | 1 | Copy finished; stays high until reset |

## Verification
The assertions check the cycle-level rules on every cycle. The read address steps by one, every read turns into a write of the same address on the next cycle, the flush state leads to done, done is sticky, nothing moves once done, and reset returns to address zero with done cleared. Only the bench's scenarios can show the end-to-end properties. These are the exact number of reads and writes, the data landing in the program and input-buffer regions, the precise cycle on which done rises, and a full second copy after a reset in mid-copy.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
    typedef enum logic [1:0] {
        ST_COPY  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DONE  = 2'd2
    } copy_state_e;
endpackage

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
    parameter int IMAGE_BYTES = 8192,
    parameter int ADDR_W      = $clog2(IMAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMAGE_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (step && (addr != LAST_ADDR)) begin
            addr <= addr + 1'b1;
        end
    end

    always_comb begin
        at_last = (addr == LAST_ADDR);
    end

    // R3: consecutive reads walk the address upward by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        step |=> (!step || (addr == $past(addr) + 1'b1)));
endmodule

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm
    import boot_copy_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic at_last,
    output logic rd_en,
    output logic done
);
    copy_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COPY:  if (at_last) state_nx = ST_FLUSH;
            ST_FLUSH: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_COPY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_COPY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        rd_en = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_COPY:  rd_en = 1'b1;
            ST_FLUSH: ;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // R6: the flush cycle is always followed by completion
    a_r6_flush_to_done: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH) |=> (state == ST_DONE));

    // R7: completion is sticky until reset
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8: reset always lands in the copy state
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (state == ST_COPY));
endmodule

// File: rtl/boot_wr_stage.sv
module boot_wr_stage #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            pend_q <= rd_en;
            if (rd_en) addr_q <= rd_addr;
        end
    end

    always_comb begin
        we      = pend_q;
        wr_addr = addr_q;
        wr_data = rd_data;
    end

    // R4: every read becomes a write to the same address one cycle later
    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (we && (wr_addr == $past(rd_addr))));
endmodule

// File: rtl/boot_image_copier.sv
module boot_image_copier #(
    parameter int IMAGE_BYTES = 8192,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = $clog2(IMAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rom_rd_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              core_hold,
    output logic              boot_done
);
    logic at_last;
    logic rd_en;
    logic done;

    boot_addr_ctr #(
        .IMAGE_BYTES (IMAGE_BYTES),
        .ADDR_W      (ADDR_W)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .step    (rd_en),
        .addr    (rom_addr),
        .at_last (at_last)
    );

    boot_copy_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .at_last (at_last),
        .rd_en   (rd_en),
        .done    (done)
    );

    boot_wr_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rom_addr),
        .rd_data (rom_data),
        .we      (ram_we),
        .wr_addr (ram_addr),
        .wr_data (ram_wdata)
    );

    always_comb begin
        rom_rd_en = rd_en;
        boot_done = done;
        core_hold = !done;
    end

    // R7: nothing is read or written once the copy has completed
    a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (!ram_we && !rom_rd_en));

    // R8: a reset restarts at address zero with done cleared
    a_r8_restart: assert property (@(posedge clk)
        rst |=> (!boot_done && (rom_addr == '0)));
endmodule

// File: tb/boot_image_copier_bench.sv
`timescale 1ns/1ps
module boot_image_copier_bench;
    localparam int IMAGE  = 8192;
    localparam int AW     = 13;
    localparam int DW     = 8;
    localparam int NSPOT  = 8;
    localparam logic [AW-1:0] SPOT_ADDR [NSPOT] = '{
        13'h0000, 13'h0001, 13'h0FFF, 13'h1000,
        13'h1001, 13'h13FF, 13'h1400, 13'h1FFF
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rom_rd_en;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data = '0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          core_hold;
    logic          boot_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] rom_fn(input logic [AW-1:0] a);
        return DW'((32'(a) * 37) ^ (32'(a) >> 5) ^ 32'hA5);
    endfunction

    always @(posedge clk) begin
        if (rom_rd_en) rom_data <= rom_fn(rom_addr);
    end

    boot_image_copier u_boot_image_copier (
        .clk       (clk),
        .rst       (rst),
        .rom_rd_en (rom_rd_en),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .core_hold (core_hold),
        .boot_done (boot_done)
    );

    // passive monitor, samples on the falling edge
    int cyc, rcount, wcount, exp_r, exp_w;
    int rd_err, seq_err, data_err, hold_err, post_err;
    int last_w, done_cyc;
    bit done_seen;
    logic [DW-1:0] capt [NSPOT];
    bit            capt_ok [NSPOT];

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; rcount = 0; wcount = 0; exp_r = 0; exp_w = 0;
            rd_err = 0; seq_err = 0; data_err = 0; hold_err = 0; post_err = 0;
            last_w = -1; done_cyc = -1; done_seen = 0;
            for (int i = 0; i < NSPOT; i++) capt_ok[i] = 0;
        end else begin
            if (rom_rd_en) begin
                if (int'(rom_addr) != exp_r) rd_err++;
                exp_r++;
                rcount++;
            end
            if (ram_we) begin
                if (int'(ram_addr) != exp_w) seq_err++;
                if (ram_wdata != rom_fn(ram_addr)) data_err++;
                for (int i = 0; i < NSPOT; i++)
                    if (ram_addr == SPOT_ADDR[i]) begin
                        capt[i] = ram_wdata;
                        capt_ok[i] = 1;
                    end
                exp_w++;
                wcount++;
                last_w = cyc;
            end
            if (!boot_done && !core_hold) hold_err++;
            if (boot_done && !done_seen) begin
                done_seen = 1;
                done_cyc = cyc;
            end
            if (done_seen && (ram_we || rom_rd_en || !boot_done)) post_err++;
            cyc++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done_seen; i++) @(negedge clk);
    endtask

    task automatic full_copy_checks(input string tag);
        check(rd_err == 0 && rcount == IMAGE, {"R3 ", tag}, rcount, IMAGE);
        check(data_err == 0, {"R4 ", tag}, data_err, 0);
        check(seq_err == 0 && wcount == IMAGE, {"R5 ", tag}, wcount, IMAGE);
        check(last_w == IMAGE && done_cyc == IMAGE + 1, {"R6 ", tag}, done_cyc, IMAGE + 1);
        check(hold_err == 0, {"R6 hold ", tag}, hold_err, 0);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!boot_done && core_hold && !ram_we, "R1 reset state",
              {boot_done, core_hold, ram_we}, 3'b010);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        // R2: first read after release
        check(rom_rd_en && rom_addr == '0, "R2 first read", int'(rom_addr), 0);
        check(!ram_we, "R1 no write first cycle", ram_we, 0);
        wait_done();
        full_copy_checks("first copy");

        // spot table: program image, input buffer, top of range
        for (int i = 0; i < NSPOT; i++)
            check(capt_ok[i] && capt[i] == rom_fn(SPOT_ADDR[i]), "R5 spot",
                  int'(capt[i]), int'(rom_fn(SPOT_ADDR[i])));

        repeat (20) @(negedge clk);
        check(post_err == 0 && boot_done, "R7 quiet and sticky", post_err, 0);

        // reset after completion
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!boot_done && core_hold, "R8 done cleared", boot_done, 0);
        @(posedge clk); #1 rst = 1'b0;
        repeat (100) @(negedge clk);
        check(!boot_done && rom_rd_en, "R8 copying again", boot_done, 0);

        // reset in mid-copy
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(rom_addr == '0 && !boot_done && rom_rd_en, "R8 restart at zero",
              int'(rom_addr), 0);
        wait_done();
        full_copy_checks("after mid reset");
        check(done_seen, "R8 copy completes", done_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule